// File: doc/BRIEF.md
# Streaming Symmetric FIR Filter

This block is a one-dimensional fixed-point FIR filter for separable two-dimensional image filtering. The same design serves as the row pass, with narrow unsigned pixels in and wider signed results out, and as the column pass, with signed samples of equal width in and out. Samples arrive on a first-word-fall-through stream: the source shows a word and an `in_exists` flag, and the filter takes the word by pulsing `in_read`. Results leave on a push stream: the filter pulses `out_write` with the data unless the sink reports `out_full`.

A run starts with a `start` pulse that carries the number of samples in the line or frame. The controller reads exactly that many samples. It then pushes `TAPS-1` zero samples to flush the delay line, waits until the pipeline is empty and returns to idle. Because the impulse response is symmetric, the two samples that share a coefficient are added before the multiply. So only `TAPS/2` coefficients are supplied and `TAPS/2` multipliers are built. The products are summed in a registered adder tree, so a longer filter adds pipeline stages but keeps the rate at one sample per cycle. While the filter is being swapped out, the `isolate` input freezes it and forces every stream output to zero.

Top module: `sym_fir_stream`

## Requirements
- R1: After reset, `in_read`, `out_write` and `busy` are low and `out_data` is zero.
- R2: For a run of L samples x[0..L-1], output m (m = 0..L-1) equals sum over i = 0..TAPS-1 of h[i]*x[m+i], where x[j] = 0 for j >= L and h[i] = h[TAPS-1-i].
- R3: A run produces exactly L output writes, in order. `busy` stays high until the last one is written, then falls.
- R4: The coefficient port holds TAPS/2 signed values. Value k sits at bits [k*COEF_W +: COEF_W] and weights both tap k and tap TAPS-1-k.
- R5: The full-precision sum is shifted arithmetically right by SHIFT (15) and saturated to the signed DOUT_W range (-32768..32767 by default).
- R6: While a result is waiting and `out_full` is high, no write is made, no input is read and the waiting result is held. No result is lost or repeated.
- R7: While `isolate` is high, `in_read` and `out_write` are low and `out_data` is zero. A run that is interrupted this way finishes correctly once `isolate` is released.
- R8: A `start` pulse with a length of zero, or one that arrives while `busy` is high, is ignored.
- R9: `in_read` is high only in a cycle where `in_exists` is high.
- R10: With `in_exists` held high and `out_full` low, the L samples of a run are read in L consecutive cycles.
- R11: With DIN_SIGNED = 0 the input is unsigned (row pass, 8 bits). With DIN_SIGNED = 1 it is two's complement (column pass, 16 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle and `frame_len` is nonzero |
| frame_len | input | CNT_W | Number of input samples in the run |
| coef | input | TAPS/2*COEF_W | Packed half set of signed coefficients |
| isolate | input | 1 | Freezes the filter and forces the stream outputs inactive |
| in_data | input | DIN_W | Input sample |
| in_exists | input | 1 | Input word available |
| in_read | output | 1 | Input word taken at this edge |
| out_data | output | DOUT_W | Filtered sample |
| out_write | output | 1 | Output word pushed at this edge |
| out_full | input | 1 | Output sink cannot accept a word |
| busy | output | 1 | A run is in progress |

## Verification
An impulse separates the coefficients by their position in the output sequence, which confirms both the packing and the mirror pairing. A ramp and an alternating pattern show the alignment of each window and the handling of the zero tail at the end of a run. Constant full-scale words in the signed 16-bit configuration drive the sum past both limits, which shows that saturation is applied after the shift. A pseudo-random stream is run under periodic backpressure, input gaps, a mid-run isolation window and a restart attempt, and is compared against the same sum computed in the bench. These runs separate dropped, repeated or misaligned results from correct stalling.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DRAIN = 2'd3
  } fir_state_e;
endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_pkg::*;
#(
  parameter int TAPS  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] frame_len,
  input  logic             in_exists,
  input  logic             en,
  input  logic             pipe_busy,
  output logic             in_read,
  output logic             flush_step,
  output logic             shift,
  output logic             clear,
  output logic             tok_valid,
  output logic             busy
);
  localparam int SW = (TAPS > 2) ? $clog2(TAPS) : 1;
  localparam logic [SW-1:0] LAST_WARM = SW'(TAPS - 1);

  fir_state_e       st_q;
  logic [CNT_W-1:0] rem_q;
  logic [SW-1:0]    flush_q;
  logic [SW-1:0]    seen_q;

  // named internal events
  assign clear      = (st_q == ST_IDLE) && start && (frame_len != '0);
  assign in_read    = (st_q == ST_RUN) && in_exists && en;
  assign flush_step = (st_q == ST_FLUSH) && en;
  assign shift      = in_read || flush_step;
  assign tok_valid  = shift && (seen_q == LAST_WARM);
  assign busy       = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rem_q   <= '0;
      flush_q <= '0;
      seen_q  <= '0;
    end else begin
      if (clear) seen_q <= '0;
      else if (shift && (seen_q != LAST_WARM)) seen_q <= seen_q + SW'(1);
      unique case (st_q)
        ST_IDLE: if (clear) begin
          st_q  <= ST_RUN;
          rem_q <= frame_len;
        end
        ST_RUN: if (in_read) begin
          rem_q <= rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) begin
            st_q    <= ST_FLUSH;
            flush_q <= LAST_WARM;
          end
        end
        ST_FLUSH: if (flush_step) begin
          flush_q <= flush_q - SW'(1);
          if (flush_q == SW'(1)) st_q <= ST_DRAIN;
        end
        ST_DRAIN: if (!pipe_busy) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3: input phase never runs with nothing left to read
  a_r3_run_remaining: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (rem_q != '0));

  // R3: flush phase always starts with TAPS-1 zero steps pending
  a_r3_flush_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FLUSH && $past(st_q) == ST_RUN) |-> (flush_q == LAST_WARM));

  // R3: idle only once every result has left the pipeline
  a_r3_idle_pipe_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !pipe_busy);
endmodule

// File: rtl/fir_taps.sv
module fir_taps #(
  parameter int TAPS       = 8,
  parameter int DIN_W      = 8,
  parameter bit DIN_SIGNED = 1'b0,
  parameter int XW         = DIN_W + 1,
  parameter int PW         = DIN_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     shift,
  input  logic                     load_zero,
  input  logic                     clear,
  input  logic                     tok_valid,
  input  logic [DIN_W-1:0]         din,
  output logic [(TAPS/2)*PW-1:0]   pre,
  output logic                     pre_v,
  output logic                     stage_busy
);
  localparam int HALF = TAPS / 2;

  logic signed [XW-1:0] taps_q [TAPS];
  logic signed [PW-1:0] pre_q  [HALF];
  logic                 a_v_q;
  logic                 b_v_q;

  // sample extension: unsigned or two's complement input
  function automatic logic signed [XW-1:0] widen(input logic [DIN_W-1:0] d);
    return DIN_SIGNED ? $signed({d[DIN_W-1], d}) : $signed({1'b0, d});
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < TAPS; j++) taps_q[j] <= '0;
      for (int k = 0; k < HALF; k++) pre_q[k] <= '0;
      a_v_q <= 1'b0;
      b_v_q <= 1'b0;
    end else begin
      if (clear) begin
        for (int j = 0; j < TAPS; j++) taps_q[j] <= '0;
        a_v_q <= 1'b0;
      end else if (en) begin
        if (shift) begin
          taps_q[0] <= load_zero ? '0 : widen(din);
          for (int j = 1; j < TAPS; j++) taps_q[j] <= taps_q[j-1];
        end
        a_v_q <= tok_valid;
      end
      if (en) begin
        for (int k = 0; k < HALF; k++)
          pre_q[k] <= PW'(taps_q[k]) + PW'(taps_q[TAPS-1-k]);
        b_v_q <= a_v_q;
      end
    end
  end

  for (genvar k = 0; k < HALF; k++) begin : g_pack
    assign pre[k*PW +: PW] = pre_q[k];
  end

  assign pre_v      = b_v_q;
  assign stage_busy = a_v_q || b_v_q;
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int HALF   = 4,
  parameter int PW     = 10,
  parameter int COEF_W = 16,
  parameter int DOUT_W = 16,
  parameter int SHIFT  = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [HALF*PW-1:0]       pre,
  input  logic                     pre_v,
  input  logic [HALF*COEF_W-1:0]   coef,
  output logic [DOUT_W-1:0]        out_q,
  output logic                     out_v,
  output logic                     stage_busy
);
  localparam int LV    = $clog2(HALF);
  localparam int PADH  = 1 << LV;
  localparam int ACC_W = PW + COEF_W + LV;
  localparam logic signed [ACC_W-1:0] OMAX =
    {{(ACC_W-DOUT_W+1){1'b0}}, {(DOUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] OMIN =
    {{(ACC_W-DOUT_W+1){1'b1}}, {(DOUT_W-1){1'b0}}};

  // heap-ordered tree: leaves PADH..2*PADH-1, root at 1
  logic signed [ACC_W-1:0] node_q [1:2*PADH-1];
  logic [LV:0]             lv_v_q;
  logic [DOUT_W-1:0]       out_q_r;
  logic                    out_v_q;

  function automatic logic signed [ACC_W-1:0] mul_pair(
    input logic [PW-1:0] p, input logic [COEF_W-1:0] c);
    return ACC_W'($signed(p)) * ACC_W'($signed(c));
  endfunction

  function automatic logic [DOUT_W-1:0] scale_sat(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] s;
    s = a >>> SHIFT;
    if (s > OMAX) return {1'b0, {(DOUT_W-1){1'b1}}};
    if (s < OMIN) return {1'b1, {(DOUT_W-1){1'b0}}};
    return s[DOUT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 1; n < 2*PADH; n++) node_q[n] <= '0;
      lv_v_q  <= '0;
      out_q_r <= '0;
      out_v_q <= 1'b0;
    end else if (en) begin
      for (int k = 0; k < PADH; k++) begin
        if (k < HALF)
          node_q[PADH+k] <= mul_pair(pre[k*PW +: PW], coef[k*COEF_W +: COEF_W]);
        else
          node_q[PADH+k] <= '0;
      end
      for (int n = 1; n < PADH; n++) node_q[n] <= node_q[2*n] + node_q[2*n+1];
      lv_v_q[0] <= pre_v;
      for (int j = 1; j <= LV; j++) lv_v_q[j] <= lv_v_q[j-1];
      out_q_r <= scale_sat(node_q[1]);
      out_v_q <= lv_v_q[LV];
    end
  end

  assign out_q      = out_q_r;
  assign out_v      = out_v_q;
  assign stage_busy = (|lv_v_q) || out_v_q;

  // R6: a stalled result stays in place and stays valid
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && out_v_q) |=> (out_v_q && $stable(out_q_r)));
endmodule

// File: rtl/sym_fir_stream.sv
module sym_fir_stream #(
  parameter int TAPS       = 8,
  parameter int DIN_W      = 8,
  parameter bit DIN_SIGNED = 1'b0,
  parameter int COEF_W     = 16,
  parameter int DOUT_W     = 16,
  parameter int SHIFT      = 15,
  parameter int CNT_W      = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [CNT_W-1:0]           frame_len,
  input  logic [(TAPS/2)*COEF_W-1:0] coef,
  input  logic                       isolate,
  input  logic [DIN_W-1:0]           in_data,
  input  logic                       in_exists,
  output logic                       in_read,
  output logic [DOUT_W-1:0]          out_data,
  output logic                       out_write,
  input  logic                       out_full,
  output logic                       busy
);
  localparam int HALF = TAPS / 2;
  localparam int XW   = DIN_W + 1;
  localparam int PW   = XW + 1;

  logic              en;
  logic              flush_step, shift, clear, tok_valid;
  logic              pipe_busy, taps_busy, mac_busy;
  logic [HALF*PW-1:0] pre;
  logic              pre_v;
  logic [DOUT_W-1:0] res_q;
  logic              res_v;

  // whole pipeline advances together unless isolated or the result is blocked
  assign en        = !isolate && !(res_v && out_full);
  assign pipe_busy = taps_busy || mac_busy;

  fir_ctrl #(.TAPS(TAPS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
    .in_exists(in_exists), .en(en), .pipe_busy(pipe_busy),
    .in_read(in_read), .flush_step(flush_step), .shift(shift),
    .clear(clear), .tok_valid(tok_valid), .busy(busy)
  );

  fir_taps #(.TAPS(TAPS), .DIN_W(DIN_W), .DIN_SIGNED(DIN_SIGNED), .XW(XW), .PW(PW)) u_taps (
    .clk(clk), .rst_n(rst_n), .en(en), .shift(shift), .load_zero(flush_step),
    .clear(clear), .tok_valid(tok_valid), .din(in_data),
    .pre(pre), .pre_v(pre_v), .stage_busy(taps_busy)
  );

  fir_mac #(.HALF(HALF), .PW(PW), .COEF_W(COEF_W), .DOUT_W(DOUT_W), .SHIFT(SHIFT)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(en), .pre(pre), .pre_v(pre_v), .coef(coef),
    .out_q(res_q), .out_v(res_v), .stage_busy(mac_busy)
  );

  assign out_write = res_v && en;
  assign out_data  = isolate ? '0 : res_q;

  // R7: isolation silences every stream output
  a_r7_isolate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    isolate |-> (!in_read && !out_write && out_data == '0));

  // R6: nothing is pushed into a full sink
  a_r6_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_full |-> !out_write);

  // R9: a read always meets an available word
  a_r9_read_has_word: assert property (@(posedge clk) disable iff (!rst_n)
    in_read |-> in_exists);
endmodule

// File: tb/test_sym_fir_stream.sv
module test_sym_fir_stream;
  localparam int TAPS  = 8;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             start_r = 1'b0, start_c = 1'b0;
  logic [CNT_W-1:0] frame_len = '0;
  logic [63:0]      coef = '0;
  logic             isolate = 1'b0;
  logic [15:0]      din = '0;
  logic             exists = 1'b0;
  logic             full = 1'b0;

  logic        rd_r, wr_r, busy_r, rd_c, wr_c, busy_c;
  logic [15:0] od_r, od_c;

  sym_fir_stream #(.TAPS(TAPS), .DIN_W(8), .DIN_SIGNED(1'b0)) i_sym_fir_stream (
    .clk(clk), .rst_n(rst_n), .start(start_r), .frame_len(frame_len), .coef(coef),
    .isolate(isolate), .in_data(din[7:0]), .in_exists(exists), .in_read(rd_r),
    .out_data(od_r), .out_write(wr_r), .out_full(full), .busy(busy_r)
  );

  sym_fir_stream #(.TAPS(TAPS), .DIN_W(16), .DIN_SIGNED(1'b1)) i_sym_fir_stream_col (
    .clk(clk), .rst_n(rst_n), .start(start_c), .frame_len(frame_len), .coef(coef),
    .isolate(isolate), .in_data(din), .in_exists(exists), .in_read(rd_c),
    .out_data(od_c), .out_write(wr_c), .out_full(full), .busy(busy_c)
  );

  int sel = 0;
  logic rd, wr, bsy;
  logic [15:0] od;
  assign rd  = (sel != 0) ? rd_c   : rd_r;
  assign wr  = (sel != 0) ? wr_c   : wr_r;
  assign bsy = (sel != 0) ? busy_c : busy_r;
  assign od  = (sel != 0) ? od_c   : od_r;

  int src [0:255];
  int cap [0:255];
  int hc  [0:3];
  int src_len = 0, src_idx = 0, cap_n = 0, feed_en = 0, gap_on = 0, bp_on = 0;
  int cyc = 0, first_rd = -1, last_rd = -1, bad_rd = 0, bad_wr = 0;
  bit rd_seen = 1'b0;
  int checks = 0, errors = 0;
  int seed = 7;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor, away from the active edge
  always @(negedge clk) begin
    rd_seen = rd;
    if (rd) begin
      if (first_rd < 0) first_rd = cyc;
      last_rd = cyc;
      if (!exists) bad_rd++;
    end
    if (wr) begin
      if (full) bad_wr++;
      if (cap_n < 256) cap[cap_n] = int'($signed(od));
      cap_n++;
    end
  end

  // stream source and sink pressure
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rd_seen) src_idx++;
    rd_seen = 1'b0;
    exists = (feed_en != 0) && (src_idx < src_len) && !((gap_on != 0) && (cyc % 3 == 1));
    din    = (src_idx < src_len) ? src[src_idx][15:0] : 16'h0;
    full   = (bp_on != 0) && (cyc % 5 < 3);
  end

  function automatic int expv(input int m, input int len);
    longint acc;
    acc = 0;
    for (int i = 0; i < TAPS; i++) begin
      int k;
      int x;
      k = (i < TAPS/2) ? i : TAPS - 1 - i;
      x = (m + i < len) ? src[m+i] : 0;
      acc += longint'(hc[k]) * longint'(x);
    end
    acc = acc >>> 15;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  task automatic set_coef(input int c0, input int c1, input int c2, input int c3);
    hc[0] = c0; hc[1] = c1; hc[2] = c2; hc[3] = c3;
    coef = {hc[3][15:0], hc[2][15:0], hc[1][15:0], hc[0][15:0]};
  endtask

  function automatic int lcg(input int span, input int base);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 32'h7fff) % span + base;
  endfunction

  task automatic run_frame(input int s, input int len, input int gap, input int bp,
                           input int iso_at, input int restart_at, input string tag);
    int k;
    int nbad;
    int fa;
    int fe;
    bit done;
    @(negedge clk);
    sel = s; src_len = len; src_idx = 0; cap_n = 0; first_rd = -1; last_rd = -1;
    bad_rd = 0; bad_wr = 0; gap_on = gap; bp_on = bp; feed_en = 1;
    @(posedge clk); #2;
    frame_len = CNT_W'(len);
    if (s != 0) start_c = 1'b1; else start_r = 1'b1;
    @(posedge clk); #2;
    start_c = 1'b0; start_r = 1'b0;
    k = 0; done = 1'b0;
    while (!done) begin
      @(posedge clk); #2;
      k++;
      if (k == iso_at) isolate = 1'b1;
      if (k == iso_at + 6) isolate = 1'b0;
      if (k == restart_at) begin
        frame_len = CNT_W'(3);
        if (s != 0) start_c = 1'b1; else start_r = 1'b1;
      end else if (k == restart_at + 1) begin
        start_c = 1'b0; start_r = 1'b0;
      end
      @(negedge clk);
      if (isolate) begin
        check(!rd && !wr, {tag, " R7 strobes"}, int'({rd, wr}), 0);
        check(od == 16'h0, {tag, " R7 data"}, int'(od), 0);
      end
      if (!bsy) done = 1'b1;
      if (k > 6000) begin
        check(1'b0, {tag, " R3 run did not end"}, k, 6000);
        done = 1'b1;
      end
    end
    feed_en = 0;
    check(cap_n == len, {tag, " R3 output count"}, cap_n, len);
    nbad = 0; fa = 0; fe = 0;
    for (int m = 0; m < len && m < cap_n; m++) begin
      if (cap[m] != expv(m, len)) begin
        if (nbad == 0) begin fa = cap[m]; fe = expv(m, len); end
        nbad++;
      end
    end
    check(nbad == 0, {tag, " R2 first mismatching output"}, fa, fe);
    check(bad_rd == 0, {tag, " R9 read without word"}, bad_rd, 0);
    check(bad_wr == 0, {tag, " R6 write into full sink"}, bad_wr, 0);
    if (gap == 0 && bp == 0 && iso_at < 0)
      check(last_rd - first_rd + 1 == len, {tag, " R10 read span"}, last_rd - first_rd + 1, len);
  endtask

  // R1
  task automatic t_reset;
    @(negedge clk);
    check(!rd_r && !wr_r && !busy_r && od_r == 16'h0, "R1 row idle after reset",
          int'({rd_r, wr_r, busy_r}), 0);
    check(!rd_c && !wr_c && !busy_c && od_c == 16'h0, "R1 column idle after reset",
          int'({rd_c, wr_c, busy_c}), 0);
  endtask

  // R4: impulse exposes each coefficient at its mirrored positions
  task automatic t_impulse;
    set_coef(1500, -4000, 9000, 20000);
    for (int i = 0; i < 20; i++) src[i] = 0;
    src[10] = 200;
    run_frame(0, 20, 0, 0, -1, -1, "R4 impulse");
    check(cap[10] == (1500 * 200) >>> 15, "R4 weight 0 at tap 0", cap[10], (1500 * 200) >>> 15);
    check(cap[3] == (1500 * 200) >>> 15, "R4 weight 0 at mirror tap", cap[3], (1500 * 200) >>> 15);
    check(cap[9] == (-4000 * 200) >>> 15, "R4 weight 1", cap[9], (-4000 * 200) >>> 15);
    check(cap[7] == (20000 * 200) >>> 15, "R4 weight 3", cap[7], (20000 * 200) >>> 15);
  endtask

  // R2 R10 R11: ramp of unsigned pixels, full rate
  task automatic t_ramp;
    for (int i = 0; i < 37; i++) src[i] = (i * 7) % 256;
    run_frame(0, 37, 0, 0, -1, -1, "R11 row ramp");
  endtask

  // R9: alternating extremes with input gaps
  task automatic t_gaps;
    for (int i = 0; i < 30; i++) src[i] = (i % 2 == 0) ? 255 : 0;
    run_frame(0, 30, 1, 0, -1, -1, "R9 gaps");
  endtask

  // R6: pseudo-random pixels under backpressure
  task automatic t_backpressure;
    for (int i = 0; i < 50; i++) src[i] = lcg(256, 0);
    run_frame(0, 50, 1, 1, -1, -1, "R6 backpressure");
  endtask

  // R7: isolation window in the middle of a run
  task automatic t_isolate;
    for (int i = 0; i < 40; i++) src[i] = lcg(256, 0);
    run_frame(0, 40, 0, 0, 12, -1, "R7 isolate");
  endtask

  // R8: zero length and restart while busy
  task automatic t_ignored_start;
    @(negedge clk);
    sel = 0; feed_en = 0;
    @(posedge clk); #2;
    frame_len = '0; start_r = 1'b1;
    @(posedge clk); #2;
    start_r = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!busy_r && !rd_r, "R8 zero length start", int'({busy_r, rd_r}), 0);
    end
    for (int i = 0; i < 25; i++) src[i] = lcg(256, 0);
    run_frame(0, 25, 0, 0, -1, 8, "R8 restart while busy");
  endtask

  // R5 R11: signed column samples driven into both limits
  task automatic t_saturate;
    set_coef(8000, 8000, 8000, 8000);
    for (int i = 0; i < 12; i++) src[i] = 32767;
    run_frame(1, 12, 0, 0, -1, -1, "R5 positive limit");
    check(cap[0] == 32767, "R5 clipped high", cap[0], 32767);
    for (int i = 0; i < 12; i++) src[i] = -32768;
    run_frame(1, 12, 0, 0, -1, -1, "R5 negative limit");
    check(cap[0] == -32768, "R5 clipped low", cap[0], -32768);
    set_coef(1500, -4000, 9000, 20000);
    for (int i = 0; i < 33; i++) src[i] = lcg(65536, -32768);
    run_frame(1, 33, 1, 1, -1, -1, "R11 column mixed");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R3 watchdog expired", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    set_coef(0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_impulse();
    t_ramp();
    t_gaps();
    t_backpressure();
    t_isolate();
    t_ignored_start();
    t_saturate();
    repeat (5) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule